// File: doc/BRIEF.md
# Serial Debug Link Wake-Up Sequencer

This block drives the host side of a two-wire serial debug link (a clock line plus a bidirectional data line) through the fixed bit stream that must come before any register access. A one-cycle `start` pulse makes the block take both lines and send the whole wake-up stream in one burst. When the last bit has been sent, the block pulses `done`, drops `busy`, releases the data pin and parks the clock low. The transaction engine that runs the register traffic then takes over the link.

The stream has six parts, sent in this order:
- eight ones, to settle the line;
- a 128-bit multi-drop selection alert, which is a module parameter;
- four zeros;
- an 8-bit activation code, sent least significant bit first;
- a line reset of 64 ones;
- eight trailing zeros.

The target samples data on the rising clock edge. The block therefore changes data only while the clock is low, and holds it for the whole high half period. Each half period lasts `HALF_DIV` system clocks. Because the target accepts any clock rate, the divider can be set to suit the cable.

Top module: `swd_wake_seq`

## Requirements
- R1: Out of reset, `swclk`, `swdio_out`, `swdio_oe`, `busy` and `done` are all 0.
- R2: In the cycle after a `start` pulse taken while idle, `busy` and `swdio_oe` are 1. A lead-in of one half period with both lines low then follows, so the first rising clock edge comes 2*`HALF_DIV` system clocks after `busy` rises.
- R3: The first 8 bits sampled on rising clock edges are all 1.
- R4: Bits 8 to 135 are the selection alert `ALERT`, sent from bit 127 down to bit 0 (default 128'h49CF9046_A9B4A161_97F5BBC7_45703D98).
- R5: Bits 136 to 139 are 0.
- R6: Bits 140 to 147 are `ACT_CODE` (default 8'h1A), sent bit 0 first, giving the wire order 0,1,0,1,1,0,0,0.
- R7: Bits 148 to 211 are all 1 (the line reset).
- R8: Bits 212 to 219 are 0. The run has exactly 220 rising edges, followed by a `done` pulse exactly one cycle wide, in the same cycle that `busy` falls.
- R9: Every high phase and every low phase between bits lasts exactly `HALF_DIV` system clocks. `swdio_out` does not change while `swclk` is high.
- R10: When the block is not busy, `swclk`, `swdio_out` and `swdio_oe` are 0.
- R11: A `start` pulse received while busy is ignored. The run continues unchanged and produces one `done`.
- R12: `swdio_oe` is 1 in every cycle in which `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send the wake-up stream |
| swclk | output | 1 | Debug link clock; target samples on its rising edge |
| swdio_out | output | 1 | Value driven onto the data pin |
| swdio_oe | output | 1 | Output enable for the data pin |
| busy | output | 1 | High from the cycle after start until done |
| done | output | 1 | One-cycle pulse when the stream is complete |

## Verification
The bench builds the block with `HALF_DIV` = 3 and keeps the default alert and activation code. An odd divider other than 1 makes every half-period count, the lead-in timing and the hold-while-high rule visible cycle by cycle. With the default constants, each of the 220 captured bits can be compared against a stream built independently from the requirements. Runs with extra `start` pulses at several points inside the burst, including during the lead-in and the line reset, show that a start arriving mid-run does not disturb the stream or the single `done`.

// File: rtl/swd_wake_pkg.sv
package swd_wake_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    ST_WAKE  = 3'd0,
    ST_ALERT = 3'd1,
    ST_ZPRE  = 3'd2,
    ST_CODE  = 3'd3,
    ST_LRST  = 3'd4,
    ST_TAIL  = 3'd5
  } stage_t;

  // Total number of bits in the wake-up stream.
  function automatic int stream_len(input int wake, input int alert, input int zpre,
                                    input int code, input int lrst, input int tail);
    return wake + alert + zpre + code + lrst + tail;
  endfunction

  // Width that can hold values 0..n-1, never below one bit.
  function automatic int idx_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/swd_wake_div.sv
module swd_wake_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = swd_wake_pkg::idx_width(HALF_DIV);
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap_w;

  assign wrap_w = (cnt_q == TOP);
  assign tick   = run && wrap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (wrap_w) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R9: the phase counter never passes the half-period length
  assert_div_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

  // R9: a half period ends by wrapping the counter back to zero
  assert_div_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

endmodule

// File: rtl/swd_wake_bits.sv
module swd_wake_bits
  import swd_wake_pkg::*;
#(
  parameter int              WAKE_ONES  = 8,
  parameter int              ALERT_LEN  = 128,
  parameter logic [127:0]    ALERT      = 128'h49CF9046_A9B4A161_97F5BBC7_45703D98,
  parameter int              ZERO_PRE   = 4,
  parameter int              CODE_LEN   = 8,
  parameter logic [7:0]      ACT_CODE   = 8'h1A,
  parameter int              RESET_ONES = 64,
  parameter int              TAIL_ZEROS = 8,
  parameter int              IW         = 8
) (
  input  logic [IW-1:0] idx_i,
  output logic          bit_o,
  output stage_t        stage_o
);
  localparam int B_WAKE  = WAKE_ONES;
  localparam int B_ALERT = B_WAKE + ALERT_LEN;
  localparam int B_ZPRE  = B_ALERT + ZERO_PRE;
  localparam int B_CODE  = B_ZPRE + CODE_LEN;
  localparam int B_LRST  = B_CODE + RESET_ONES;
  localparam int AW      = idx_width(ALERT_LEN);
  localparam int KW      = idx_width(CODE_LEN);

  int            pos;
  logic [AW-1:0] a_sel;
  logic [KW-1:0] k_sel;

  always_comb begin
    pos   = int'(idx_i);
    a_sel = AW'(B_ALERT - 1 - pos);
    k_sel = KW'(pos - B_ZPRE);
    if (pos < B_WAKE) begin
      stage_o = ST_WAKE;
      bit_o   = 1'b1;
    end else if (pos < B_ALERT) begin
      stage_o = ST_ALERT;
      bit_o   = ALERT[a_sel];
    end else if (pos < B_ZPRE) begin
      stage_o = ST_ZPRE;
      bit_o   = 1'b0;
    end else if (pos < B_CODE) begin
      stage_o = ST_CODE;
      bit_o   = ACT_CODE[k_sel];
    end else if (pos < B_LRST) begin
      stage_o = ST_LRST;
      bit_o   = 1'b1;
    end else begin
      stage_o = ST_TAIL;
      bit_o   = 1'b0;
    end
  end

endmodule

// File: rtl/swd_wake_seq.sv
module swd_wake_seq
  import swd_wake_pkg::*;
#(
  parameter int           HALF_DIV   = 4,
  parameter int           WAKE_ONES  = 8,
  parameter int           ALERT_LEN  = 128,
  parameter logic [127:0] ALERT      = 128'h49CF9046_A9B4A161_97F5BBC7_45703D98,
  parameter int           ZERO_PRE   = 4,
  parameter int           CODE_LEN   = 8,
  parameter logic [7:0]   ACT_CODE   = 8'h1A,
  parameter int           RESET_ONES = 64,
  parameter int           TAIL_ZEROS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic swclk,
  output logic swdio_out,
  output logic swdio_oe,
  output logic busy,
  output logic done
);
  localparam int TOTAL = stream_len(WAKE_ONES, ALERT_LEN, ZERO_PRE,
                                    CODE_LEN, RESET_ONES, TAIL_ZEROS);
  localparam int IW = idx_width(TOTAL);
  localparam logic [IW-1:0] LAST_IDX = IW'(TOTAL - 1);

  phase_t        state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          tick_w, last_w, fin_w;
  logic          bit_nx_w, bit_now_w;
  stage_t        stage_nx_w, stage_now_w;
  logic          swclk_q, dio_q, oe_q, done_q;

  swd_wake_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q != PH_IDLE),
    .tick (tick_w)
  );

  // Bit for the index to be driven next.
  swd_wake_bits #(
    .WAKE_ONES(WAKE_ONES), .ALERT_LEN(ALERT_LEN), .ALERT(ALERT),
    .ZERO_PRE(ZERO_PRE), .CODE_LEN(CODE_LEN), .ACT_CODE(ACT_CODE),
    .RESET_ONES(RESET_ONES), .TAIL_ZEROS(TAIL_ZEROS), .IW(IW)
  ) bits_nx_i (
    .idx_i  (idx_d),
    .bit_o  (bit_nx_w),
    .stage_o(stage_nx_w)
  );

  // Stage of the bit now on the wire, brought out for the checks.
  swd_wake_bits #(
    .WAKE_ONES(WAKE_ONES), .ALERT_LEN(ALERT_LEN), .ALERT(ALERT),
    .ZERO_PRE(ZERO_PRE), .CODE_LEN(CODE_LEN), .ACT_CODE(ACT_CODE),
    .RESET_ONES(RESET_ONES), .TAIL_ZEROS(TAIL_ZEROS), .IW(IW)
  ) bits_now_i (
    .idx_i  (idx_q),
    .bit_o  (bit_now_w),
    .stage_o(stage_now_w)
  );

  assign last_w = (idx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fin_w   = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start) begin
        state_d = PH_LEAD;
        idx_d   = '0;
      end
      PH_LEAD: if (tick_w) state_d = PH_LOW;
      PH_LOW:  if (tick_w) state_d = PH_HIGH;
      PH_HIGH: if (tick_w) begin
        if (last_w) begin
          state_d = PH_IDLE;
          fin_w   = 1'b1;
        end else begin
          state_d = PH_LOW;
          idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      idx_q   <= '0;
      swclk_q <= 1'b0;
      dio_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      swclk_q <= (state_d == PH_HIGH);
      dio_q   <= ((state_d == PH_LOW) || (state_d == PH_HIGH)) && bit_nx_w;
      oe_q    <= (state_d != PH_IDLE);
      done_q  <= fin_w;
    end
  end

  assign swclk     = swclk_q;
  assign swdio_out = dio_q;
  assign swdio_oe  = oe_q;
  assign busy      = (state_q != PH_IDLE);
  assign done      = done_q;

  // R2: an accepted start leads in with both lines low and the pin driven
  assert_start_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && swdio_oe && !swclk && !swdio_out));

  // R3: the settle bits are all ones at the sampling edge
  assert_wake_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && stage_now_w == ST_WAKE) |-> swdio_out);

  // R5: the zero prefix is low at the sampling edge
  assert_zero_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && stage_now_w == ST_ZPRE) |-> !swdio_out);

  // R6: the activation code bit on the wire matches the selected code bit
  assert_code_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && stage_now_w == ST_CODE) |-> (swdio_out == bit_now_w));

  // R7: the line reset is all ones at the sampling edge
  assert_line_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && stage_now_w == ST_LRST) |-> swdio_out);

  // R8: the tail is low and done is a single-cycle pulse after busy ends
  assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && stage_now_w == ST_TAIL) |-> !swdio_out);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)) ##1 !done);

  // R9: data holds still while the clock is high
  assert_hold_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> $stable(swdio_out));

  // R9: the first bit sent after a start is a settle bit
  assert_first_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_LEAD && state_d == PH_LOW) |-> (stage_nx_w == ST_WAKE));

  // R10: idle lines are low and released
  assert_idle_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!swclk && !swdio_oe && !swdio_out));

  // R11: a start during a run never restarts the lead-in
  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state_q != PH_LEAD) |=> (state_q != PH_LEAD));

  // R12: the pin is driven for the whole run
  assert_oe_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> swdio_oe);

endmodule

// File: tb/swd_wake_seq_tb_top.sv
module swd_wake_seq_tb_top;
  localparam int HALF = 3;
  localparam int NBITS = 220;
  localparam logic [127:0] ALERT_V = 128'h49CF9046_A9B4A161_97F5BBC7_45703D98;
  localparam logic [7:0] CODE_V = 8'h1A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic swclk, swdio_out, swdio_oe, busy, done;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  swd_wake_seq #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
    .busy(busy), .done(done)
  );

  // ---- monitor, sampled on falling system clock ----
  logic cap [0:255];
  int   n_edges, hi_len, lo_len, bad_len, bad_hold, oe_bad;
  int   lead_cycles, lead_bad, done_cnt, done_wide;
  logic prev_clk, prev_dio, prev_done, mon_en;

  task automatic clear_mon();
    n_edges = 0; hi_len = 0; lo_len = 0; bad_len = 0; bad_hold = 0;
    oe_bad = 0; lead_cycles = 0; lead_bad = 0; done_cnt = 0; done_wide = 0;
    prev_clk = 1'b0; prev_dio = 1'b0; prev_done = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (busy && !swdio_oe) oe_bad++;
      if (done) begin
        done_cnt++;
        if (prev_done) done_wide++;
      end
      if (busy && n_edges == 0 && !swclk) begin
        if (lead_cycles < HALF && swdio_out) lead_bad++;
        lead_cycles++;
      end
      if (swclk && !prev_clk) begin
        if (n_edges < 256) cap[n_edges] = swdio_out;
        if (n_edges > 0 && lo_len != HALF) bad_len++;
        n_edges++;
        hi_len = 1;
      end else if (swclk) begin
        hi_len++;
        if (swdio_out != prev_dio) bad_hold++;
      end
      if (!swclk && prev_clk) begin
        if (hi_len != HALF) bad_len++;
        lo_len = 1;
      end else if (!swclk) begin
        lo_len++;
      end
      prev_clk  = swclk;
      prev_dio  = swdio_out;
      prev_done = done;
    end
  end

  // ---- expected stream, built from the requirements ----
  function automatic logic exp_bit(input int i);
    if (i < 8)   return 1'b1;                  // R3
    if (i < 136) return ALERT_V[127 - (i - 8)]; // R4
    if (i < 140) return 1'b0;                  // R5
    if (i < 148) return CODE_V[i - 140];       // R6
    if (i < 212) return 1'b1;                  // R7
    return 1'b0;                               // R8
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic check_seg(input string req, input int lo, input int hi);
    int miss = 0;
    int first = -1;
    for (int i = lo; i < hi; i++) begin
      if (cap[i] !== exp_bit(i)) begin
        miss++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = lo;
    check(miss == 0, req, int'(cap[first]), int'(exp_bit(first)));
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 5000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({swclk, swdio_out, swdio_oe, busy, done} == 5'b0, "R1 reset state",
          int'({swclk, swdio_out, swdio_oe, busy, done}), 0);
  endtask

  task automatic run_and_check(input string tag, input int hit1, input int hit2);
    bit seen;
    clear_mon();
    pulse_start();
    #1;
    check(busy && swdio_oe, {tag, " R2 busy/oe after start"}, int'({busy, swdio_oe}), 3);
    fork
      begin
        if (hit1 > 0) begin
          repeat (hit1) @(posedge clk);
          pulse_start();
        end
        if (hit2 > 0) begin
          repeat (hit2) @(posedge clk);
          pulse_start();
        end
      end
      wait_done(seen);
    join
    check(seen, {tag, " R8 done seen"}, int'(seen), 1);
    check(!busy, {tag, " R8 busy low with done"}, int'(busy), 0);
    @(negedge clk);
    #1;
    check(!done, {tag, " R8 done one cycle"}, int'(done), 0);
    check({swclk, swdio_out, swdio_oe} == 3'b0, {tag, " R10 idle lines"},
          int'({swclk, swdio_out, swdio_oe}), 0);
    repeat (4 * HALF) @(negedge clk);
    check(lead_cycles == 2 * HALF, {tag, " R2 first edge delay"}, lead_cycles, 2 * HALF);
    check(lead_bad == 0, {tag, " R2 lead data low"}, lead_bad, 0);
    check(n_edges == NBITS, {tag, " R8 edge count"}, n_edges, NBITS);
    check_seg({tag, " R3 wake ones"}, 0, 8);
    check_seg({tag, " R4 alert"}, 8, 136);
    check_seg({tag, " R5 zero prefix"}, 136, 140);
    check_seg({tag, " R6 code lsb first"}, 140, 148);
    check_seg({tag, " R7 line reset"}, 148, 212);
    check_seg({tag, " R8 tail zeros"}, 212, 220);
    check(bad_len == 0, {tag, " R9 half period length"}, bad_len, 0);
    check(bad_hold == 0, {tag, " R9 hold while high"}, bad_hold, 0);
    check(oe_bad == 0, {tag, " R12 oe while busy"}, oe_bad, 0);
    check(done_cnt == 1 && done_wide == 0, {tag, " R11 single done"}, done_cnt, 1);
    check({swclk, swdio_oe, busy} == 3'b0, {tag, " R10 stays idle"},
          int'({swclk, swdio_oe, busy}), 0);
  endtask

  // Code bits in wire order, checked by name for R6.
  task automatic t_code_order();
    logic [7:0] wire_ord;
    for (int i = 0; i < 8; i++) wire_ord[7 - i] = cap[140 + i];
    check(wire_ord == 8'b0101_1000, "R6 wire order 01011000", int'(wire_ord), 8'h58);
  endtask

  initial begin
    mon_en = 1'b0;
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    mon_en = 1'b1;
    run_and_check("plain", 0, 0);
    t_code_order();
    // R11: starts during lead-in and during the line reset
    run_and_check("restart", 2, 900);
    // R11: start during the alert
    run_and_check("alert-hit", 200, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule